// File: doc/BRIEF.md
# Display Window Pixel Unpacker

This block sits between a frame-buffer fetch queue and the compositor of one overlay window. It takes 32-bit words from the head of the queue and turns them into one 24-bit RGB pixel and a one-bit alpha (visibility) flag for each pixel-clock enable. A format code selects the layout of the stored pixels. Palettised depths of 1, 2, 4 and 8 bits per pixel index a palette RAM. Direct-colour layouts carry the colour in the word itself. Fields narrower than 8 bits are widened by copying their top bits into the vacated low bits. A per-window swap control reverses the order in which the pixel slots of a word are read out. It acts on bits for the sub-byte depths, on bytes for 8 bpp and on half-words for 16 bpp.

The palette has a CPU write port that is open only while the palette-update control is high. While that control is high, the palette is cut off from the display path and palettised pixels repeat the last colour looked up. A constant-colour override replaces every pixel with a programmed colour and stops word consumption. A low window enable silences the output. A format code that names no supported layout gives transparent black.

Top module: `win_pixel_unpack`

## Requirements
- R1: While reset is high and after it is released, with no pixel enable, `pix_valid`, `pix_rgb`, `pix_alpha` and `word_pop` are all 0.
- R2: A pixel enable sampled at a rising edge produces its pixel with `pix_valid` high after exactly the second following rising edge. Each enable yields exactly one pixel. Without swap, slot k of a word with b bits per pixel is bits [k*b +: b], so the slot at bit 0 comes first.
- R3: `word_pop` is high, in the same cycle, exactly when a pixel enable consumes the last slot of the current word (32/b slots per word). The next word is taken from `word_data` from the following enable on.
- R4: Format codes 0, 1, 2 and 3 are palettised at 1, 2, 4 and 8 bpp. The slot value indexes the palette, and the pixel is that entry with alpha 1.
- R5: A palette write lands only when `pal_we` and `pal_upd` are both high at a rising edge. A write with `pal_upd` low has no effect.
- R6: While `pal_upd` is high, palettised pixels repeat the last colour looked up before it rose.
- R7: Code 4 is 8 bpp with alpha at bit 7, red at 6:5, green at 4:2 and blue at 1:0. Code 5 is 16 bpp with red at 15:11, green at 10:5, blue at 4:0 and alpha 1. Code 6 is 16 bpp with alpha at bit 15, red at 14:10, green at 9:5 and blue at 4:0. Each channel is widened to 8 bits by repeating its top bits below it.
- R8: Codes 7 to 10 hold one pixel per word. Code 7 is 6:6:6 with red at 17:12, green at 11:6, blue at 5:0 and alpha 1, and code 8 is the same with alpha at bit 18. Code 9 is 8:8:8 with red at 23:16, green at 15:8, blue at 7:0 and alpha 1, and code 10 is the same with alpha at bit 24.
- R9: With `swap_en` high, slot k is read from slot (32/b-1-k) instead. For one-pixel-per-word codes, swap has no effect.
- R10: With `map_en` high and the window enabled, every pixel is `map_color` with alpha 1 and no word is consumed.
- R11: With `win_en` low, enables produce no valid pixel and no `word_pop`, and the slot position returns to slot 0.
- R12: With the window enabled and `map_en` low, codes 11 to 15 produce valid pixels with RGB 0 and alpha 0 and consume no words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| win_en | input | 1 | Window enable |
| fmt | input | 4 | Pixel format code |
| swap_en | input | 1 | Reverse slot order inside the word |
| map_en | input | 1 | Constant-colour override enable |
| map_color | input | 24 | Override colour |
| pix_ce | input | 1 | Pixel-clock enable, one pixel per high cycle |
| word_data | input | 32 | Word at the head of the fetch queue |
| word_pop | output | 1 | Head word fully consumed this cycle |
| pal_upd | input | 1 | Palette update: opens writes, detaches lookup |
| pal_we | input | 1 | Palette write strobe |
| pal_addr | input | PAL_AW | Palette write address |
| pal_wdata | input | COLOR_W | Palette write colour |
| pix_valid | output | 1 | Output pixel valid |
| pix_rgb | output | COLOR_W | Output colour, red in the top byte |
| pix_alpha | output | 1 | Output visibility flag |

## Verification
Every pixel result is due after the second rising edge following the edge that sampled its enable: one edge for slot selection and the palette read, one for the output register. `word_pop` is due in the same cycle as the enable that consumes a word's last slot. The bench drives inputs and samples outputs on falling edges. It checks the two-edge delay directly once, then records every valid pixel in order and compares the n-th record with the model of the n-th enable. It also counts pops against the number of whole words in the run. Because every scenario ends with idle cycles before the comparison, no pixel still in the pipeline can be left out.

// File: rtl/wpu_pkg.sv
package wpu_pkg;

  localparam int WORD_W = 32;
  localparam int SLOT_W = 5;

  typedef enum logic [3:0] {
    FMT_P1       = 4'd0,
    FMT_P2       = 4'd1,
    FMT_P4       = 4'd2,
    FMT_P8       = 4'd3,
    FMT_D8_A232  = 4'd4,
    FMT_D16_565  = 4'd5,
    FMT_D16_A555 = 4'd6,
    FMT_D32_666  = 4'd7,
    FMT_D32_A666 = 4'd8,
    FMT_D32_888  = 4'd9,
    FMT_D32_A888 = 4'd10
  } fmt_e;

  typedef enum logic [2:0] {
    K_OFF, K_MAP, K_BAD, K_PAL, K_DIR
  } kind_e;

  // log2 of bits per pixel for a format code
  function automatic logic [2:0] bpp_log2(input logic [3:0] m);
    case (m)
      FMT_P1:                    return 3'd0;
      FMT_P2:                    return 3'd1;
      FMT_P4:                    return 3'd2;
      FMT_P8, FMT_D8_A232:       return 3'd3;
      FMT_D16_565, FMT_D16_A555: return 3'd4;
      default:                   return 3'd5;
    endcase
  endfunction

  function automatic logic fmt_ok(input logic [3:0] m);
    return m <= FMT_D32_A888;
  endfunction

  function automatic logic fmt_pal(input logic [3:0] m);
    return m <= FMT_P8;
  endfunction

endpackage

// File: rtl/wpu_slot_pick.sv
module wpu_slot_pick
  import wpu_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic [3:0]        mode,
  input  logic              swap,
  input  logic [SLOT_W-1:0] idx,
  output logic [24:0]       raw,
  output logic              last
);
  logic [2:0]        lg;
  logic [SLOT_W-1:0] ppw_m1;
  logic [SLOT_W-1:0] slot;
  logic [SLOT_W-1:0] bitpos;
  logic [WORD_W-1:0] mask;

  always_comb begin
    lg     = bpp_log2(mode);
    ppw_m1 = SLOT_W'((6'd32 >> lg) - 6'd1);
    slot   = swap ? (ppw_m1 - idx) : idx;
    bitpos = slot << lg;
    mask   = (lg == 3'd5) ? '1 : ((32'd1 << (6'd1 << lg)) - 32'd1);
    raw    = 25'((word >> bitpos) & mask);
    last   = (idx == ppw_m1);
  end

endmodule

// File: rtl/wpu_palette.sv
module wpu_palette #(
  parameter int AW = 8,
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          upd,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // write port open only while detached from the display path
  always_ff @(posedge clk) begin
    if (we && upd) mem[waddr] <= wdata;
  end

  // read port frozen while detached, so the last colour is held
  always_ff @(posedge clk) begin
    if (re && !upd) rdata <= mem[raddr];
  end

  // R6: lookup output must not move while the update control is high
  p_pal_hold_r6: assert property (@(posedge clk) disable iff (rst)
    upd |=> $stable(rdata));

endmodule

// File: rtl/wpu_direct_expand.sv
module wpu_direct_expand
  import wpu_pkg::*;
(
  input  logic [3:0]  mode,
  input  logic [24:0] raw,
  output logic [23:0] rgb,
  output logic        alpha
);
  always_comb begin
    rgb   = '0;
    alpha = 1'b1;
    case (mode)
      FMT_D8_A232: begin
        alpha = raw[7];
        rgb   = {{4{raw[6:5]}}, raw[4:2], raw[4:2], raw[4:3], {4{raw[1:0]}}};
      end
      FMT_D16_565:
        rgb = {raw[15:11], raw[15:13], raw[10:5], raw[10:9], raw[4:0], raw[4:2]};
      FMT_D16_A555: begin
        alpha = raw[15];
        rgb   = {raw[14:10], raw[14:12], raw[9:5], raw[9:7], raw[4:0], raw[4:2]};
      end
      FMT_D32_666, FMT_D32_A666: begin
        alpha = (mode == FMT_D32_A666) ? raw[18] : 1'b1;
        rgb   = {raw[17:12], raw[17:16], raw[11:6], raw[11:10], raw[5:0], raw[5:4]};
      end
      FMT_D32_888, FMT_D32_A888: begin
        alpha = (mode == FMT_D32_A888) ? raw[24] : 1'b1;
        rgb   = raw[23:0];
      end
      default: begin
        alpha = 1'b0;
        rgb   = '0;
      end
    endcase
  end

endmodule

// File: rtl/win_pixel_unpack.sv
module win_pixel_unpack
  import wpu_pkg::*;
#(
  parameter int PAL_AW  = 8,
  parameter int COLOR_W = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               win_en,
  input  logic [3:0]         fmt,
  input  logic               swap_en,
  input  logic               map_en,
  input  logic [COLOR_W-1:0] map_color,
  input  logic               pix_ce,
  input  logic [WORD_W-1:0]  word_data,
  output logic               word_pop,
  input  logic               pal_upd,
  input  logic               pal_we,
  input  logic [PAL_AW-1:0]  pal_addr,
  input  logic [COLOR_W-1:0] pal_wdata,
  output logic               pix_valid,
  output logic [COLOR_W-1:0] pix_rgb,
  output logic               pix_alpha
);
  logic [SLOT_W-1:0]  idx;
  logic [24:0]        raw;
  logic               last;
  logic               fetching;
  kind_e              kind_now;

  logic               s1_valid;
  kind_e              s1_kind;
  logic [24:0]        s1_raw;
  logic [3:0]         s1_mode;
  logic [COLOR_W-1:0] s1_color;

  logic [COLOR_W-1:0] pal_q;
  logic [23:0]        dir_rgb;
  logic               dir_alpha;

  wpu_slot_pick u_pick (
    .word (word_data),
    .mode (fmt),
    .swap (swap_en),
    .idx  (idx),
    .raw  (raw),
    .last (last)
  );

  always_comb begin
    fetching = win_en && !map_en && fmt_ok(fmt);
    if (!win_en)          kind_now = K_OFF;
    else if (map_en)      kind_now = K_MAP;
    else if (!fmt_ok(fmt)) kind_now = K_BAD;
    else if (fmt_pal(fmt)) kind_now = K_PAL;
    else                  kind_now = K_DIR;
  end

  // fetch strobe to the queue in front of the block
  assign word_pop = pix_ce && fetching && last;

  always_ff @(posedge clk) begin
    if (rst || !fetching) idx <= '0;
    else if (pix_ce)      idx <= last ? '0 : idx + 1'b1;
  end

  // stage 1: slot selection and palette read
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_kind  <= K_OFF;
      s1_raw   <= '0;
      s1_mode  <= '0;
      s1_color <= '0;
    end else begin
      s1_valid <= pix_ce && win_en;
      if (pix_ce) begin
        s1_kind  <= kind_now;
        s1_raw   <= raw;
        s1_mode  <= fmt;
        s1_color <= map_color;
      end
    end
  end

  wpu_palette #(.AW(PAL_AW), .DW(COLOR_W)) u_pal (
    .clk   (clk),
    .rst   (rst),
    .upd   (pal_upd),
    .we    (pal_we),
    .waddr (pal_addr),
    .wdata (pal_wdata),
    .re    (pix_ce && fetching && fmt_pal(fmt)),
    .raddr (raw[PAL_AW-1:0]),
    .rdata (pal_q)
  );

  wpu_direct_expand u_dir (
    .mode  (s1_mode),
    .raw   (s1_raw),
    .rgb   (dir_rgb),
    .alpha (dir_alpha)
  );

  // stage 2: registered output
  always_ff @(posedge clk) begin
    if (rst) begin
      pix_valid <= 1'b0;
      pix_rgb   <= '0;
      pix_alpha <= 1'b0;
    end else begin
      pix_valid <= s1_valid;
      pix_rgb   <= '0;
      pix_alpha <= 1'b0;
      if (s1_valid) begin
        case (s1_kind)
          K_MAP: begin pix_rgb <= s1_color;          pix_alpha <= 1'b1;      end
          K_PAL: begin pix_rgb <= pal_q;             pix_alpha <= 1'b1;      end
          K_DIR: begin pix_rgb <= COLOR_W'(dir_rgb); pix_alpha <= dir_alpha; end
          default: begin pix_rgb <= '0;              pix_alpha <= 1'b0;      end
        endcase
      end
    end
  end

  // R11: a disabled window yields no pixel two edges later
  p_off_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    (pix_ce && !win_en) |-> ##2 !pix_valid);

  // R11: no fetch while disabled
  p_off_nofetch_r11: assert property (@(posedge clk) disable iff (rst)
    !win_en |-> !word_pop);

  // R10: override consumes no words
  p_map_nofetch_r10: assert property (@(posedge clk) disable iff (rst)
    map_en |-> !word_pop);

  // R10: override pixel carries the colour sampled with its enable
  p_map_color_r10: assert property (@(posedge clk) disable iff (rst)
    (pix_ce && win_en && map_en) |-> ##2
      (pix_valid && pix_alpha && pix_rgb == $past(map_color, 2)));

  // R12: unsupported code gives valid transparent black
  p_bad_black_r12: assert property (@(posedge clk) disable iff (rst)
    (pix_ce && win_en && !map_en && !fmt_ok(fmt)) |-> ##2
      (pix_valid && !pix_alpha && pix_rgb == '0));

endmodule

// File: tb/win_pixel_unpack_test.sv
module win_pixel_unpack_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        win_en = 1'b0;
  logic [3:0]  fmt = 4'd0;
  logic        swap_en = 1'b0;
  logic        map_en = 1'b0;
  logic [23:0] map_color = 24'd0;
  logic        pix_ce = 1'b0;
  logic [31:0] word_data;
  logic        word_pop;
  logic        pal_upd = 1'b0;
  logic        pal_we = 1'b0;
  logic [7:0]  pal_addr = 8'd0;
  logic [23:0] pal_wdata = 24'd0;
  logic        pix_valid;
  logic [23:0] pix_rgb;
  logic        pix_alpha;

  int n_chk = 0;
  int n_bad = 0;

  logic [31:0] fifo_mem [16];
  logic [23:0] pal_m [256];
  logic [24:0] cap [64];
  int ncap = 0;
  int npop = 0;
  int rd_start = 0;

  always #4 clk = ~clk;

  win_pixel_unpack uut (
    .clk(clk), .rst(rst), .win_en(win_en), .fmt(fmt), .swap_en(swap_en),
    .map_en(map_en), .map_color(map_color), .pix_ce(pix_ce),
    .word_data(word_data), .word_pop(word_pop), .pal_upd(pal_upd),
    .pal_we(pal_we), .pal_addr(pal_addr), .pal_wdata(pal_wdata),
    .pix_valid(pix_valid), .pix_rgb(pix_rgb), .pix_alpha(pix_alpha)
  );

  assign word_data = fifo_mem[4'(npop - rd_start)];

  always @(posedge clk) if (word_pop) npop <= npop + 1;

  always @(negedge clk) begin
    if (pix_valid && ncap < 64) begin
      cap[ncap] = {pix_alpha, pix_rgb};
      ncap = ncap + 1;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int ppw_of(input logic [3:0] m);
    case (m)
      4'd0: return 32;
      4'd1: return 16;
      4'd2: return 8;
      4'd3, 4'd4: return 4;
      4'd5, 4'd6: return 2;
      default: return 1;
    endcase
  endfunction

  function automatic logic [24:0] model_px(input logic [3:0] m, input logic sw,
                                           input logic [31:0] w, input int k);
    int p, b, s;
    logic [31:0] v;
    p = ppw_of(m);
    b = 32 / p;
    s = sw ? (p - 1 - k) : k;
    v = (b == 32) ? w : ((w >> (s * b)) & ((32'd1 << b) - 32'd1));
    case (m)
      4'd0, 4'd1, 4'd2, 4'd3: return {1'b1, pal_m[v[7:0]]};
      4'd4:  return {v[7], {4{v[6:5]}}, v[4:2], v[4:2], v[4:3], {4{v[1:0]}}};
      4'd5:  return {1'b1, v[15:11], v[15:13], v[10:5], v[10:9], v[4:0], v[4:2]};
      4'd6:  return {v[15], v[14:10], v[14:12], v[9:5], v[9:7], v[4:0], v[4:2]};
      4'd7:  return {1'b1, v[17:12], v[17:16], v[11:6], v[11:10], v[5:0], v[5:4]};
      4'd8:  return {v[18], v[17:12], v[17:16], v[11:6], v[11:10], v[5:0], v[5:4]};
      4'd9:  return {1'b1, v[23:0]};
      4'd10: return {v[24], v[23:0]};
      default: return 25'd0;
    endcase
  endfunction

  task automatic pal_write(input logic [7:0] a, input logic [23:0] d);
    @(negedge clk);
    pal_we = 1'b1; pal_addr = a; pal_wdata = d;
    if (pal_upd) pal_m[a] = d;
    @(negedge clk);
    pal_we = 1'b0;
  endtask

  // run n enables in format m; compare against model or a held colour
  task automatic run_px(input string req, input logic [3:0] m, input logic sw,
                        input int n, input logic hold, input logic [23:0] hv);
    int p;
    logic [24:0] e;
    @(negedge clk);
    win_en = 1'b0; fmt = m; swap_en = sw; map_en = 1'b0; pix_ce = 1'b0;
    @(negedge clk);
    win_en = 1'b1; rd_start = npop; ncap = 0;
    begin
      int pop0 = npop;
      repeat (n) begin pix_ce = 1'b1; @(negedge clk); end
      pix_ce = 1'b0;
      repeat (3) @(negedge clk);
      p = ppw_of(m);
      chk(req, "pixel count", ncap, n);
      chk(req, "word pops", npop - pop0, n / p);
    end
    for (int j = 0; j < n && j < ncap; j++) begin
      e = hold ? {1'b1, hv} : model_px(m, sw, fifo_mem[j / p], j % p);
      chk(req, $sformatf("pixel %0d", j), {7'd0, cap[j]}, {7'd0, e});
    end
  endtask

  task automatic t_reset;
    chk("R1", "valid in reset", {31'd0, pix_valid}, 32'd0);
    chk("R1", "pop in reset", {31'd0, word_pop}, 32'd0);
    @(negedge clk); rst = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1", "valid after reset", {31'd0, pix_valid}, 32'd0);
    chk("R1", "rgb after reset", {8'd0, pix_rgb}, 32'd0);
    chk("R1", "alpha after reset", {31'd0, pix_alpha}, 32'd0);
  endtask

  task automatic t_latency;
    @(negedge clk);
    win_en = 1'b0; fmt = 4'd9; swap_en = 1'b0; map_en = 1'b0;
    @(negedge clk);
    win_en = 1'b1; rd_start = npop; pix_ce = 1'b1;
    @(negedge clk);
    pix_ce = 1'b0;
    chk("R2", "valid after one edge", {31'd0, pix_valid}, 32'd0);
    @(negedge clk);
    chk("R2", "valid after two edges", {31'd0, pix_valid}, 32'd1);
    chk("R2", "rgb after two edges", {8'd0, pix_rgb}, {8'd0, fifo_mem[0][23:0]});
    @(negedge clk);
    chk("R2", "single pixel per enable", {31'd0, pix_valid}, 32'd0);
  endtask

  task automatic t_map;
    int pop0;
    @(negedge clk);
    win_en = 1'b1; fmt = 4'd3; map_en = 1'b1; map_color = 24'h3C5A96;
    ncap = 0; pop0 = npop;
    repeat (6) begin pix_ce = 1'b1; @(negedge clk); end
    pix_ce = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10", "override pixel count", ncap, 6);
    chk("R10", "override pops", npop - pop0, 0);
    for (int j = 0; j < ncap; j++)
      chk("R10", "override colour", {7'd0, cap[j]}, {7'd0, 1'b1, 24'h3C5A96});
    map_en = 1'b0;
  endtask

  task automatic t_disabled;
    int pop0;
    @(negedge clk);
    win_en = 1'b0; fmt = 4'd0; ncap = 0; pop0 = npop;
    repeat (40) begin pix_ce = 1'b1; @(negedge clk); end
    pix_ce = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11", "disabled pixel count", ncap, 0);
    chk("R11", "disabled pops", npop - pop0, 0);
  endtask

  task automatic t_bad;
    int pop0;
    @(negedge clk);
    win_en = 1'b1; fmt = 4'd13; map_en = 1'b0; ncap = 0; pop0 = npop;
    repeat (4) begin pix_ce = 1'b1; @(negedge clk); end
    pix_ce = 1'b0;
    repeat (3) @(negedge clk);
    chk("R12", "bad-code pixel count", ncap, 4);
    chk("R12", "bad-code pops", npop - pop0, 0);
    for (int j = 0; j < ncap; j++)
      chk("R12", "bad-code pixel", {7'd0, cap[j]}, 32'd0);
  endtask

  task automatic t_palette_ctrl;
    logic [23:0] held;
    // R5: write with update low is ignored
    pal_write(8'h30, 24'hDEAD01);
    for (int i = 0; i < 16; i++) fifo_mem[i] = 32'h0000_0030;
    run_px("R5", 4'd3, 1'b0, 4, 1'b0, 24'd0);
    // R6: hold last colour while detached
    for (int i = 0; i < 16; i++) fifo_mem[i] = 32'h1010_1010;
    run_px("R4", 4'd3, 1'b0, 4, 1'b0, 24'd0);
    held = pal_m[8'h10];
    @(negedge clk); pal_upd = 1'b1;
    pal_write(8'h10, 24'h111111);
    pal_write(8'h20, 24'h222222);
    for (int i = 0; i < 16; i++) fifo_mem[i] = 32'h2020_2020;
    run_px("R6", 4'd3, 1'b0, 8, 1'b1, held);
    @(negedge clk); pal_upd = 1'b0;
    for (int i = 0; i < 16; i++) fifo_mem[i] = 32'h1020_2010;
    run_px("R5", 4'd3, 1'b0, 4, 1'b0, 24'd0);
    chk("R5", "written entry seen", {8'd0, pal_m[8'h20]}, 32'h00222222);
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++)
      fifo_mem[i] = 32'h9E3779B9 * 32'(i + 1) ^ 32'h5A5A0F0F;
    t_reset();
    pal_upd = 1'b1;
    for (int i = 0; i < 256; i++)
      pal_write(8'(i), {8'(i) ^ 8'h5A, ~8'(i), 8'(i) + 8'd7});
    pal_upd = 1'b0;
    t_latency();
    run_px("R4 R2 R3", 4'd0, 1'b0, 40, 1'b0, 24'd0);
    run_px("R4 R9", 4'd0, 1'b1, 32, 1'b0, 24'd0);
    run_px("R4 R3", 4'd1, 1'b0, 20, 1'b0, 24'd0);
    run_px("R4 R9", 4'd1, 1'b1, 16, 1'b0, 24'd0);
    run_px("R4 R9", 4'd2, 1'b1, 16, 1'b0, 24'd0);
    run_px("R4", 4'd3, 1'b0, 2, 1'b0, 24'd0);
    run_px("R11 R4", 4'd3, 1'b0, 8, 1'b0, 24'd0);
    run_px("R4 R9", 4'd3, 1'b1, 8, 1'b0, 24'd0);
    run_px("R7", 4'd4, 1'b0, 8, 1'b0, 24'd0);
    run_px("R7 R9", 4'd4, 1'b1, 4, 1'b0, 24'd0);
    run_px("R7", 4'd5, 1'b0, 4, 1'b0, 24'd0);
    run_px("R7 R9", 4'd5, 1'b1, 4, 1'b0, 24'd0);
    run_px("R7", 4'd6, 1'b0, 6, 1'b0, 24'd0);
    run_px("R8", 4'd7, 1'b0, 3, 1'b0, 24'd0);
    run_px("R8", 4'd8, 1'b0, 4, 1'b0, 24'd0);
    run_px("R8 R9", 4'd9, 1'b1, 3, 1'b0, 24'd0);
    run_px("R8", 4'd10, 1'b0, 4, 1'b0, 24'd0);
    run_px("R8 R9", 4'd10, 1'b1, 2, 1'b0, 24'd0);
    t_map();
    t_disabled();
    t_bad();
    t_palette_ctrl();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule